// File: doc/BRIEF.md
# Guarded System Control Register Bank

This block is a bank of system control registers on a simple 32-bit register bus. It decodes a 4 KB window with a 12-bit byte address. The bank holds several kinds of state. An identification word is fixed by a parameter. An LED register drives output pins. Two general configuration words are freely readable and writable. A guard register must hold a special key before the reset-level register takes writes. There are two flag words, each with one address that sets bits and another that clears them. One of the two flag words keeps its contents across a block reset. A free-running tick counter advances at a nominal 24 MHz, derived from the bus clock by a fractional accumulator. A few read-only constants complete the map.

The board variant comes from the 12-bit field in bits 27:16 of the identification parameter. The variant decides whether the reset-level register accepts writes and which data bit requests a system reset. It also decides whether that register reads back at all. The system reset request is a one-cycle output pulse. Any access to an offset that is not defined for its direction, or to a misaligned offset, reads as zero and raises a one-cycle error strobe.

Bus timing: a cycle with `bus_sel` high at a rising edge is an access; `bus_wr` selects a write. Read data is combinational from the current state. Register updates, `bus_err` and `sys_reset_req` all appear in the cycle after the access edge.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, offsets 0x08, 0x20, 0x28, 0x2C, 0x30 and 0x40 read zero, `led_o` is zero, and offset 0x00 reads the identification parameter.
- R2: A write of exactly 0x0000A05F to 0x20 stores 0xA05F and unlocks the bank. Any other write stores data[14:0] zero-extended and leaves it locked. Offset 0x20 reads the stored value.
- R3: A write to 0x30 ORs the data into the volatile flags, a write to 0x34 clears the flag bits set in the data, and 0x30 reads the flags.
- R4: The persistent flags are set through 0x38 and cleared through 0x3C. They read at 0x38, start at a parameter value, and keep their value through a block reset.
- R5: A write to 0x40 updates the reset-level register only while unlocked, and only on variants 0x100, 0x178 and 0x182. On other variants, and while locked, the write leaves the register unchanged.
- R6: An accepted 0x40 write pulses `sys_reset_req` high for exactly the next cycle when the variant's trigger bit is 1 in the data. The trigger bit is bit 8 for variant 0x100 and bit 2 for variants 0x178 and 0x182.
- R7: On variant 0x190, offset 0x40 reads zero.
- R8: Offset 0x5C reads a 32-bit counter. Over any N clock cycles it advances by N*TICK_HZ/CLK_HZ when that is an integer, and by at most 1 per cycle.
- R9: Offset 0x44 reads 1, offset 0x84 reads the processor ID parameter, and offset 0x88 reads 0xFF000000.
- R10: Some accesses are not defined for their direction: reads other than 0x00, 0x08, 0x20, 0x28, 0x2C, 0x30, 0x38, 0x40, 0x44, 0x5C, 0x84 and 0x88; writes other than 0x08, 0x20, 0x28, 0x2C, 0x30, 0x34, 0x38, 0x3C and 0x40; and any misaligned offset. Such an access raises `bus_err` for the next cycle, a read of it returns zero, and a write of it changes no state. Defined accesses never raise `bus_err`.
- R11: Offsets 0x28 and 0x2C are plain 32-bit read/write words. Offset 0x08 stores data[LED_W-1:0], reads it back zero-extended, and drives `led_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Undefined-access strobe, one cycle after the access |
| led_o | output | LED_W | LED register contents |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the assertions check several properties. The reset request lasts one cycle and always follows an unlocked write to the reset-level offset. A locked write there leaves the register unchanged. Set and clear writes act on the flag bits they name. A rejected key always leaves the bank locked. The counter never steps by more than one, and the error strobe only follows an access. Only the bench's scenarios can show the values the bus reads back. These include the per-variant reset-level behaviour across three instances, the persistent flags surviving a reset, the exact 24 MHz count over a long window, and the zero read and strobe for undefined offsets.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam logic [11:0] OFS_IDENT  = 12'h000;
   localparam logic [11:0] OFS_LED    = 12'h008;
   localparam logic [11:0] OFS_GUARD  = 12'h020;
   localparam logic [11:0] OFS_CFGA   = 12'h028;
   localparam logic [11:0] OFS_CFGB   = 12'h02C;
   localparam logic [11:0] OFS_VSET   = 12'h030;
   localparam logic [11:0] OFS_VCLR   = 12'h034;
   localparam logic [11:0] OFS_PSET   = 12'h038;
   localparam logic [11:0] OFS_PCLR   = 12'h03C;
   localparam logic [11:0] OFS_RLVL   = 12'h040;
   localparam logic [11:0] OFS_ONE    = 12'h044;
   localparam logic [11:0] OFS_TICK   = 12'h05C;
   localparam logic [11:0] OFS_CPUID  = 12'h084;
   localparam logic [11:0] OFS_TOPBYT = 12'h088;

   localparam logic [31:0] GUARD_KEY  = 32'h0000_A05F;
   localparam logic [31:0] TOPBYT_VAL = 32'hFF00_0000;

   // Variant codes that change reset-level behaviour
   localparam logic [11:0] VAR_BIT8   = 12'h100;
   localparam logic [11:0] VAR_BIT2A  = 12'h178;
   localparam logic [11:0] VAR_BIT2B  = 12'h182;
   localparam logic [11:0] VAR_HIDDEN = 12'h190;

   // Trigger bit index for a variant, -1 when reset-level writes are ignored
   function automatic int trig_bit_of(logic [11:0] v);
      if (v == VAR_BIT8) return 8;
      if (v == VAR_BIT2A || v == VAR_BIT2B) return 2;
      return -1;
   endfunction

endpackage

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
   parameter int          W         = 32,
   parameter bit          HAS_RESET = 1'b1,
   parameter logic [31:0] INIT      = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);

   initial begin
      if (W < 1 || W > 32) $fatal(1, "sysctl_setclr: W out of range");
   end

   logic [W-1:0] nxt;
   always_comb begin
      nxt = q;
      if (set_en) nxt = nxt | wd;
      if (clr_en) nxt = nxt & ~wd;
   end

   generate
      if (HAS_RESET) begin : g_rst
         logic [W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= nxt;
         end
         assign q = q_r;
      end else begin : g_keep
         logic [W-1:0] q_r = INIT[W-1:0];
         always_ff @(posedge clk) begin
            q_r <= nxt;
         end
         assign q = q_r;
      end
   endgenerate

   // R3 / R4: set writes leave the named bits high, clear writes leave them low
   assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en) |=> ((q & $past(wd)) == $past(wd)));
   assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((q & $past(wd)) == '0));

endmodule

// File: rtl/sysctl_guard.sv
module sysctl_guard (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wd,
   output logic [15:0] guard_q,
   output logic        unlocked
);
   import sysctl_pkg::*;

   logic key_hit;
   assign key_hit = (wd == GUARD_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      guard_q <= '0;
      else if (wr_en)  guard_q <= key_hit ? GUARD_KEY[15:0] : {1'b0, wd[14:0]};
   end

   assign unlocked = (guard_q == GUARD_KEY[15:0]);

   // R2: any rejected key leaves the bank locked
   assert_bad_key_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wd != GUARD_KEY) |=> !unlocked);
   // R2: only the key can hold the top bit of the stored value
   assert_guard_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
      guard_q[15] |-> unlocked);

endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
   parameter int CLK_HZ  = 50_000_000,
   parameter int TICK_HZ = 24_000_000,
   parameter int CW      = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt
);

   localparam int AW = $clog2(CLK_HZ) + 2;
   localparam logic [AW-1:0] STEP = AW'(TICK_HZ);
   localparam logic [AW-1:0] LIM  = AW'(CLK_HZ);

   initial begin
      if (TICK_HZ < 1 || TICK_HZ > CLK_HZ) $fatal(1, "sysctl_tick: TICK_HZ must be 1..CLK_HZ");
   end

   logic [AW-1:0] acc;
   logic [AW-1:0] sum;
   assign sum = acc + STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         cnt <= '0;
      end else if (sum >= LIM) begin
         acc <= sum - LIM;
         cnt <= cnt + 1'b1;
      end else begin
         acc <= sum;
      end
   end

   // R8: the count never moves by more than one per clock
   assert_tick_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
   parameter logic [31:0] SYS_ID  = 32'h0100_0000,
   parameter logic [31:0] PROC_ID = 32'h0C00_0000,
   parameter int          LED_W   = 8,
   parameter int          CLK_HZ  = 50_000_000,
   parameter int          TICK_HZ = 24_000_000,
   parameter logic [31:0] NV_INIT = 32'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [11:0]      bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             bus_err,
   output logic [LED_W-1:0] led_o,
   output logic             sys_reset_req
);
   import sysctl_pkg::*;

   localparam logic [11:0] VARIANT  = SYS_ID[27:16];
   localparam int          TRIG_BIT = trig_bit_of(VARIANT);
   localparam bit          RL_SHOWN = (VARIANT != VAR_HIDDEN);

   initial begin
      if (LED_W < 1 || LED_W > 32) $fatal(1, "sysctl_regs: LED_W must be 1..32");
      if (TICK_HZ > CLK_HZ)        $fatal(1, "sysctl_regs: TICK_HZ above CLK_HZ");
   end

   // ---------------- decode ----------------
   logic wr, rd;
   assign wr = bus_sel &  bus_wr;
   assign rd = bus_sel & ~bus_wr;

   logic wr_led, wr_guard, wr_cfga, wr_cfgb, wr_vset, wr_vclr, wr_pset, wr_pclr, wr_rl;
   assign wr_led   = wr && bus_addr == OFS_LED;
   assign wr_guard = wr && bus_addr == OFS_GUARD;
   assign wr_cfga  = wr && bus_addr == OFS_CFGA;
   assign wr_cfgb  = wr && bus_addr == OFS_CFGB;
   assign wr_vset  = wr && bus_addr == OFS_VSET;
   assign wr_vclr  = wr && bus_addr == OFS_VCLR;
   assign wr_pset  = wr && bus_addr == OFS_PSET;
   assign wr_pclr  = wr && bus_addr == OFS_PCLR;
   assign wr_rl    = wr && bus_addr == OFS_RLVL;

   logic wr_known, rd_known;
   always_comb begin
      unique case (bus_addr)
         OFS_LED, OFS_GUARD, OFS_CFGA, OFS_CFGB, OFS_VSET,
         OFS_VCLR, OFS_PSET, OFS_PCLR, OFS_RLVL: wr_known = 1'b1;
         default:                                wr_known = 1'b0;
      endcase
      unique case (bus_addr)
         OFS_IDENT, OFS_LED, OFS_GUARD, OFS_CFGA, OFS_CFGB, OFS_VSET,
         OFS_PSET, OFS_RLVL, OFS_ONE, OFS_TICK, OFS_CPUID, OFS_TOPBYT: rd_known = 1'b1;
         default:                                                      rd_known = 1'b0;
      endcase
   end

   // ---------------- plain storage ----------------
   logic [LED_W-1:0] led_q;
   logic [31:0]      cfga_q, cfgb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q  <= '0;
         cfga_q <= '0;
         cfgb_q <= '0;
      end else begin
         if (wr_led)  led_q  <= bus_wdata[LED_W-1:0];
         if (wr_cfga) cfga_q <= bus_wdata;
         if (wr_cfgb) cfgb_q <= bus_wdata;
      end
   end
   assign led_o = led_q;

   // ---------------- sub-blocks ----------------
   logic [15:0] guard_q;
   logic        unlocked;
   sysctl_guard u_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_guard), .wd(bus_wdata),
      .guard_q(guard_q), .unlocked(unlocked)
   );

   logic [31:0] vflags, pflags;
   sysctl_setclr #(.W(32), .HAS_RESET(1'b1), .INIT(32'h0)) u_vflags (
      .clk(clk), .rst_n(rst_n), .set_en(wr_vset), .clr_en(wr_vclr),
      .wd(bus_wdata), .q(vflags)
   );
   sysctl_setclr #(.W(32), .HAS_RESET(1'b0), .INIT(NV_INIT)) u_pflags (
      .clk(clk), .rst_n(rst_n), .set_en(wr_pset), .clr_en(wr_pclr),
      .wd(bus_wdata), .q(pflags)
   );

   logic [31:0] tick;
   sysctl_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CW(32)) u_tick (
      .clk(clk), .rst_n(rst_n), .cnt(tick)
   );

   // ---------------- reset level, variant selected ----------------
   logic [31:0] rl_val;
   logic        rr_q;

   generate
      if (TRIG_BIT >= 0) begin : g_rl
         logic [31:0] rl_q;
         logic        take;
         assign take = wr_rl && unlocked;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rl_q <= '0;
               rr_q <= 1'b0;
            end else begin
               rr_q <= take && bus_wdata[TRIG_BIT];
               if (take) rl_q <= bus_wdata;
            end
         end
         assign rl_val = rl_q;

         // R5: a locked write leaves the register unchanged
         assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_rl && !unlocked) |=> $stable(rl_q));
      end else begin : g_no_rl
         assign rl_val = '0;
         assign rr_q   = 1'b0;
      end
   endgenerate

   assign sys_reset_req = rr_q;

   // ---------------- error strobe ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_err <= 1'b0;
      else        bus_err <= bus_sel && !(bus_wr ? wr_known : rd_known);
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         unique case (bus_addr)
            OFS_IDENT:  bus_rdata = SYS_ID;
            OFS_LED:    bus_rdata = 32'(led_q);
            OFS_GUARD:  bus_rdata = {16'h0, guard_q};
            OFS_CFGA:   bus_rdata = cfga_q;
            OFS_CFGB:   bus_rdata = cfgb_q;
            OFS_VSET:   bus_rdata = vflags;
            OFS_PSET:   bus_rdata = pflags;
            OFS_RLVL:   bus_rdata = RL_SHOWN ? rl_val : 32'h0;
            OFS_ONE:    bus_rdata = 32'h1;
            OFS_TICK:   bus_rdata = tick;
            OFS_CPUID:  bus_rdata = PROC_ID;
            OFS_TOPBYT: bus_rdata = TOPBYT_VAL;
            default:    bus_rdata = '0;
         endcase
      end
   end

   // R6: the request is one cycle wide and follows an unlocked reset-level write
   assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |=> !sys_reset_req);
   assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> $past(wr_rl && unlocked));
   // R10: the strobe only follows an access
   assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_sel));

endmodule

// File: tb/tb_sysctl_regs.sv
module tb_sysctl_regs;

   localparam int NI = 3;
   localparam logic [31:0] ID0 = 32'h0100_0000;
   localparam logic [31:0] ID1 = 32'h0182_0000;
   localparam logic [31:0] ID2 = 32'h0190_0000;
   localparam logic [31:0] PID = 32'h0C00_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdat [NI];
   logic        err  [NI];
   logic        rreq [NI];
   logic [7:0]  led  [NI];

   always #10 clk = ~clk;

   sysctl_regs #(.SYS_ID(ID0), .PROC_ID(PID)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdat[0]),
      .bus_err(err[0]), .led_o(led[0]), .sys_reset_req(rreq[0]));
   sysctl_regs #(.SYS_ID(ID1), .PROC_ID(PID)) dut_b (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdat[1]),
      .bus_err(err[1]), .led_o(led[1]), .sys_reset_req(rreq[1]));
   sysctl_regs #(.SYS_ID(ID2), .PROC_ID(PID)) dut_c (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdat[2]),
      .bus_err(err[2]), .led_o(led[2]), .sys_reset_req(rreq[2]));

   int n_chk = 0, n_bad = 0;

   // reference model
   logic [7:0]  m_led;
   logic [15:0] m_guard;
   logic [31:0] m_cfga, m_cfgb, m_vf, m_pf = 32'h0;
   logic [31:0] m_rl [NI];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] id_of(int k);
      return (k == 0) ? ID0 : (k == 1) ? ID1 : ID2;
   endfunction

   function automatic bit rd_def(logic [11:0] a);
      case (a)
         12'h000, 12'h008, 12'h020, 12'h028, 12'h02C, 12'h030, 12'h038,
         12'h040, 12'h044, 12'h05C, 12'h084, 12'h088: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit wr_def(logic [11:0] a);
      case (a)
         12'h008, 12'h020, 12'h028, 12'h02C, 12'h030, 12'h034,
         12'h038, 12'h03C, 12'h040: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_rd(int k, logic [11:0] a);
      case (a)
         12'h000: return id_of(k);
         12'h008: return {24'h0, m_led};
         12'h020: return {16'h0, m_guard};
         12'h028: return m_cfga;
         12'h02C: return m_cfgb;
         12'h030: return m_vf;
         12'h038: return m_pf;
         12'h040: return (k == 2) ? 32'h0 : m_rl[k];
         12'h044: return 32'h1;
         12'h084: return PID;
         12'h088: return 32'hFF00_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [11:0] a);
      case (a)
         12'h008, 12'h028, 12'h02C: return "R11";
         12'h020:                   return "R2";
         12'h030, 12'h034:          return "R3";
         12'h038, 12'h03C:          return "R4";
         12'h040:                   return "R5";
         12'h044, 12'h084, 12'h088: return "R9";
         12'h000:                   return "R1";
         default:                   return "R10";
      endcase
   endfunction

   task automatic model_reset();
      m_led = '0; m_guard = '0; m_cfga = '0; m_cfgb = '0; m_vf = '0;
      for (int k = 0; k < NI; k++) m_rl[k] = '0;
   endtask

   task automatic do_wr(logic [11:0] a, logic [31:0] d);
      bit unl;
      bit exp_rr [NI];
      unl = (m_guard == 16'hA05F);
      exp_rr[0] = (a == 12'h040) && unl && d[8];
      exp_rr[1] = (a == 12'h040) && unl && d[2];
      exp_rr[2] = 1'b0;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      case (a)
         12'h008: m_led = d[7:0];
         12'h020: m_guard = (d == 32'h0000_A05F) ? 16'hA05F : {1'b0, d[14:0]};
         12'h028: m_cfga = d;
         12'h02C: m_cfgb = d;
         12'h030: m_vf = m_vf | d;
         12'h034: m_vf = m_vf & ~d;
         12'h038: m_pf = m_pf | d;
         12'h03C: m_pf = m_pf & ~d;
         12'h040: if (unl) begin m_rl[0] = d; m_rl[1] = d; end
         default: ;
      endcase
      for (int k = 0; k < NI; k++) begin
         chk("R6 reset pulse", {31'h0, rreq[k]}, {31'h0, exp_rr[k]});
         chk("R10 write strobe", {31'h0, err[k]}, {31'h0, !wr_def(a)});
         chk("R11 led pins", {24'h0, led[k]}, {24'h0, m_led});
      end
   endtask

   task automatic do_rd(logic [11:0] a, output logic [31:0] v0);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      v0 = rdat[0];
      if (a != 12'h05C)
         for (int k = 0; k < NI; k++) chk(tag_of(a), rdat[k], exp_rd(k, a));
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0;
      for (int k = 0; k < NI; k++)
         chk("R10 read strobe", {31'h0, err[k]}, {31'h0, !rd_def(a)});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
   endtask

   logic [11:0] pool [16] = '{12'h000, 12'h008, 12'h020, 12'h028, 12'h02C, 12'h030,
                              12'h034, 12'h038, 12'h03C, 12'h040, 12'h044, 12'h084,
                              12'h088, 12'h00C, 12'h022, 12'h100};

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog all-R actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] v, t0, t1;
      void'($urandom(32'd1234));
      model_reset();
      @(negedge clk);
      do_reset();

      // R1: reset state
      for (int k = 0; k < NI; k++) chk("R1 led after reset", {24'h0, led[k]}, 32'h0);
      do_rd(12'h000, v); do_rd(12'h008, v); do_rd(12'h020, v);
      do_rd(12'h028, v); do_rd(12'h02C, v); do_rd(12'h030, v); do_rd(12'h040, v);

      // R9 constants
      do_rd(12'h044, v); do_rd(12'h084, v); do_rd(12'h088, v);

      // R2/R5: near-miss key stays locked, reset-level write ignored
      do_wr(12'h020, 32'h0001_A05F);
      do_rd(12'h020, v);
      chk("R2 masked near key", v, 32'h0000_205F);
      do_wr(12'h040, 32'hFFFF_FFFF);
      do_rd(12'h040, v);
      chk("R5 locked write ignored", v, 32'h0);

      // R2/R5/R6/R7: unlock, write with both trigger bits
      do_wr(12'h020, 32'h0000_A05F);
      do_rd(12'h020, v);
      do_wr(12'h040, 32'h0000_0104);
      @(negedge clk);
      for (int k = 0; k < NI; k++) chk("R6 pulse one cycle", {31'h0, rreq[k]}, 32'h0);
      do_rd(12'h040, v);
      do_wr(12'h040, 32'h0000_0100);
      do_wr(12'h040, 32'h0000_0004);
      do_wr(12'h040, 32'h0000_0030);

      // R3 / R4 / R11 directed
      do_wr(12'h030, 32'hF0F0_0000); do_wr(12'h034, 32'h3000_0000); do_rd(12'h030, v);
      do_wr(12'h038, 32'h00C0_FFEE); do_wr(12'h03C, 32'h0000_00EE); do_rd(12'h038, v);
      do_wr(12'h008, 32'hDEAD_BEA5); do_rd(12'h008, v);

      // R4: persistent flags survive reset, volatile ones do not
      do_reset();
      do_rd(12'h038, v);
      chk("R4 persists over reset", v, 32'h00C0_FF00);
      do_rd(12'h030, v);
      do_rd(12'h020, v);

      // R10: undefined write changes nothing
      do_wr(12'h024, 32'hFFFF_FFFF);
      do_wr(12'h02A, 32'hFFFF_FFFF);
      do_rd(12'h028, v);
      do_wr(12'h000, 32'h1234_5678);
      do_rd(12'h000, v);
      do_rd(12'h034, v);
      do_rd(12'hFFC, v);

      // R8: tick rate over 1000 cycles
      do_rd(12'h05C, t0);
      repeat (999) @(negedge clk);
      do_rd(12'h05C, t1);
      chk("R8 tick rate", t1 - t0, 32'd480);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [11:0] a;
         logic [31:0] d;
         a = pool[$urandom_range(15)];
         d = $urandom();
         if (a == 12'h020 && $urandom_range(1)) d = 32'h0000_A05F;
         if ($urandom_range(2) == 0) do_rd(a, v);
         else                        do_wr(a, d);
         if ($urandom_range(99) == 0) do_reset();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule